// File: doc/BRIEF.md
# Converter Start-up Sequencer

This block brings a sampled-data converter out of power-down in a fixed order after its active-low power-down pin is driven high. It first waits a fixed number of master clock cycles and then drops the internal power-down. After a short gap measured in frame clock edges it releases the digital filter reset. It keeps the sample outputs forced to two's-complement zero until a mode-dependent number of frame clock edges has been counted from the release point, and then raises a data-valid flag.

The frame clock is synchronous to the master clock and is sampled by it. In master mode the sequence starts on the first master clock edge that sees the pin high. In slave mode it waits for the frame clock edge that begins a frame: a rising edge in left-justified format, a falling edge in I2S format. That same edge is the one the frame count runs on. The mode and format are captured when the sequence starts. Driving the pin low at any time, even for a single clock, throws away all progress.

Top module: `pdn_init_seq`

## Requirements
- R1: While the pin is sampled low, and in the cycle after, `pwr_down_o`, `filt_rst_o` and `zero_force_o` are 1 and `data_valid_o` is 0. The same holds out of reset.
- R2: A low pin sampled on any clock edge clears every counter. The next start, whatever its stage, runs its full length again.
- R3: `pwr_down_o` falls on the clock edge that comes MCLK_WAIT (default 147456) edges after the start edge.
- R4: In slave mode the start edge is the first active frame clock edge after the pin is high: rising for `i2s_i`=0, falling for `i2s_i`=1. In master mode it is the first clock edge that samples the pin high.
- R5: `filt_rst_o` falls on the GAP_FRAMES-th (default 3) active frame clock edge after `pwr_down_o` has fallen.
- R6: `data_valid_o` rises on the clock edge after the count of active frame edges since the start edge reaches INIT_MASTER (default 4129) in master mode or INIT_SLAVE (default 4132) in slave mode. The start edge itself is not counted. If the filter reset is still asserted at that point, `data_valid_o` rises on the following clock edge instead.
- R7: `zero_force_o` is the inverse of `data_valid_o` at all times, so the valid flag rises in the very cycle the forcing ends.
- R8: `master_i` and `i2s_i` are sampled only on the start cycle. Changes made later in a sequence do not alter its timing.
- R9: The releases occur in a fixed order. `filt_rst_o` is never low while `pwr_down_o` is high, and `zero_force_o` is never low while `filt_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| pdn_ni | input | 1 | power-down pin, active low, synchronous to clk_i |
| frame_clk_i | input | 1 | frame clock, synchronous to clk_i |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| i2s_i | input | 1 | 1 = I2S format (falling-edge frames), 0 = left-justified |
| pwr_down_o | output | 1 | internal power-down, active high |
| filt_rst_o | output | 1 | digital filter reset, active high |
| zero_force_o | output | 1 | force sample outputs to zero |
| data_valid_o | output | 1 | sample outputs valid |

## Verification
All four outputs are decoded from a registered state, so each one changes one master clock edge after the input sample that causes it. A low pin sampled on edge N shows at the outputs after edge N. A release counted on edge N also shows after edge N, and the valid flag comes one edge after the frame edge that completes its count. The bench drives inputs and samples outputs on the falling clock edge. A behavioural model advances on the rising edge from the same inputs and is compared against every output on every falling edge. The frame clock runs at 8 master clocks per frame, and the parameters are reduced so that each corner is reached within a few hundred cycles.

// File: rtl/pdn_seq_pkg.sv
package pdn_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_ALIGN = 3'd1,
    ST_PWAIT = 3'd2,
    ST_GAP   = 3'd3,
    ST_INIT  = 3'd4,
    ST_RUN   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/seq_edge_det.sv
module seq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int MAX   = 15,
  localparam int W    = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_TOP = W'(MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_o <= '0;
    else if (clr_i)                     cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_TOP) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import pdn_seq_pkg::*;
#(
  parameter int MCLK_WAIT   = 147456,
  parameter int GAP_FRAMES  = 3,
  parameter int INIT_MASTER = 4129,
  parameter int INIT_SLAVE  = 4132,
  localparam int FMAX = (INIT_MASTER > INIT_SLAVE) ? INIT_MASTER : INIT_SLAVE,
  localparam int MCW  = $clog2(MCLK_WAIT + 1),
  localparam int GCW  = $clog2(GAP_FRAMES + 1),
  localparam int FCW  = $clog2(FMAX + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pdn_ni,
  input  logic           master_i,
  input  logic           i2s_i,
  input  logic           rise_i,
  input  logic           fall_i,
  input  logic [MCW-1:0] mcnt_i,
  input  logic [GCW-1:0] gcnt_i,
  input  logic [FCW-1:0] fcnt_i,
  output logic           m_clr_o,
  output logic           m_inc_o,
  output logic           g_clr_o,
  output logic           g_inc_o,
  output logic           f_clr_o,
  output logic           f_inc_o,
  output logic           pwr_down_o,
  output logic           filt_rst_o,
  output logic           zero_force_o,
  output logic           data_valid_o
);
  localparam logic [MCW-1:0] M_LAST = MCW'(MCLK_WAIT - 1);
  localparam logic [GCW-1:0] G_LAST = GCW'(GAP_FRAMES - 1);
  localparam logic [FCW-1:0] T_MST  = FCW'(INIT_MASTER);
  localparam logic [FCW-1:0] T_SLV  = FCW'(INIT_SLAVE);

  seq_state_e state_q, state_d;
  logic       master_q, i2s_q;
  logic       act;
  logic [FCW-1:0] target;

  assign act    = i2s_q ? fall_i : rise_i;
  assign target = master_q ? T_MST : T_SLV;

  always_comb begin
    state_d = state_q;
    if (!pdn_ni) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:   state_d = master_i ? ST_PWAIT : ST_ALIGN;
        ST_ALIGN: if (act) state_d = ST_PWAIT;
        ST_PWAIT: if (mcnt_i == M_LAST) state_d = ST_GAP;
        ST_GAP:   if (act && gcnt_i == G_LAST) state_d = ST_INIT;
        ST_INIT:  if (fcnt_i >= target) state_d = ST_RUN;
        ST_RUN:   state_d = ST_RUN;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OFF;
      master_q <= 1'b0;
      i2s_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_OFF && pdn_ni) begin
        master_q <= master_i;
        i2s_q    <= i2s_i;
      end
    end
  end

  // counter control
  assign m_clr_o = !pdn_ni || state_q != ST_PWAIT;
  assign m_inc_o = pdn_ni && state_q == ST_PWAIT;
  assign g_clr_o = !pdn_ni || state_q != ST_GAP;
  assign g_inc_o = act && state_q == ST_GAP;
  assign f_clr_o = !pdn_ni || state_q == ST_OFF || state_q == ST_ALIGN;
  assign f_inc_o = act && (state_q == ST_PWAIT || state_q == ST_GAP || state_q == ST_INIT);

  assign pwr_down_o   = state_q == ST_OFF || state_q == ST_ALIGN || state_q == ST_PWAIT;
  assign filt_rst_o   = pwr_down_o || state_q == ST_GAP;
  assign zero_force_o = state_q != ST_RUN;
  assign data_valid_o = state_q == ST_RUN;

  AST_PIN_LOW_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_ni |=> (pwr_down_o && filt_rst_o && zero_force_o && !data_valid_o)); // R1
  AST_CNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_ni |=> (mcnt_i == '0 && gcnt_i == '0 && fcnt_i == '0)); // R2
  AST_PWR_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_ni && $fell(pwr_down_o)) |-> $past(mcnt_i) == M_LAST); // R3
  AST_FILT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_ni && $fell(filt_rst_o)) |-> $past(gcnt_i) == G_LAST); // R5
  AST_VALID_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_valid_o) |-> $past(fcnt_i) >= $past(target)); // R6
endmodule

// File: rtl/pdn_init_seq.sv
module pdn_init_seq #(
  parameter int MCLK_WAIT   = 147456,
  parameter int GAP_FRAMES  = 3,
  parameter int INIT_MASTER = 4129,
  parameter int INIT_SLAVE  = 4132
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pdn_ni,
  input  logic frame_clk_i,
  input  logic master_i,
  input  logic i2s_i,
  output logic pwr_down_o,
  output logic filt_rst_o,
  output logic zero_force_o,
  output logic data_valid_o
);
  localparam int FMAX = (INIT_MASTER > INIT_SLAVE) ? INIT_MASTER : INIT_SLAVE;
  localparam int MCW  = $clog2(MCLK_WAIT + 1);
  localparam int GCW  = $clog2(GAP_FRAMES + 1);
  localparam int FCW  = $clog2(FMAX + 1);

  logic           rise, fall;
  logic           m_clr, m_inc, g_clr, g_inc, f_clr, f_inc;
  logic [MCW-1:0] mcnt;
  logic [GCW-1:0] gcnt;
  logic [FCW-1:0] fcnt;

  seq_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (frame_clk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  seq_counter #(.MAX(MCLK_WAIT)) u_mclk_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (m_clr), .inc_i (m_inc), .cnt_o (mcnt)
  );

  seq_counter #(.MAX(GAP_FRAMES)) u_gap_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (g_clr), .inc_i (g_inc), .cnt_o (gcnt)
  );

  seq_counter #(.MAX(FMAX)) u_frame_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (f_clr), .inc_i (f_inc), .cnt_o (fcnt)
  );

  seq_fsm #(
    .MCLK_WAIT   (MCLK_WAIT),
    .GAP_FRAMES  (GAP_FRAMES),
    .INIT_MASTER (INIT_MASTER),
    .INIT_SLAVE  (INIT_SLAVE)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pdn_ni       (pdn_ni),
    .master_i     (master_i),
    .i2s_i        (i2s_i),
    .rise_i       (rise),
    .fall_i       (fall),
    .mcnt_i       (mcnt),
    .gcnt_i       (gcnt),
    .fcnt_i       (fcnt),
    .m_clr_o      (m_clr),
    .m_inc_o      (m_inc),
    .g_clr_o      (g_clr),
    .g_inc_o      (g_inc),
    .f_clr_o      (f_clr),
    .f_inc_o      (f_inc),
    .pwr_down_o   (pwr_down_o),
    .filt_rst_o   (filt_rst_o),
    .zero_force_o (zero_force_o),
    .data_valid_o (data_valid_o)
  );
endmodule

// File: tb/pdn_init_seq_bench.sv
module pdn_init_seq_bench;
  localparam int MW   = 40;
  localparam int GF   = 3;
  localparam int IM   = 9;
  localparam int IS   = 12;
  localparam int FMAX = (IM > IS) ? IM : IS;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, pdn_n = 1'b0, fclk = 1'b0, master = 1'b0, i2s = 1'b0;
  logic pwr_down_o, filt_rst_o, zero_force_o, data_valid_o;
  int   checks = 0, fails = 0;
  bit   done = 1'b0, flip = 1'b0;

  always #2.5 clk = ~clk;

  pdn_init_seq #(.MCLK_WAIT(MW), .GAP_FRAMES(GF), .INIT_MASTER(IM), .INIT_SLAVE(IS)) u_pdn_init_seq (
    .clk_i (clk), .rst_ni (rst_n), .pdn_ni (pdn_n), .frame_clk_i (fclk),
    .master_i (master), .i2s_i (i2s),
    .pwr_down_o (pwr_down_o), .filt_rst_o (filt_rst_o),
    .zero_force_o (zero_force_o), .data_valid_o (data_valid_o)
  );

  int fdiv = 0;
  always @(negedge clk) begin
    if (fdiv == HALF - 1) begin fdiv <= 0; fclk <= ~fclk; end
    else fdiv <= fdiv + 1;
  end

  // behavioural reference: ph 0 off,1 wait frame edge,2 mclk wait,3 filter gap,4 zero fill,5 valid
  int ph = 0, mc = 0, fc = 0, gc = 0;
  bit mm = 1'b0, mi = 1'b0, pf = 1'b0;
  always @(posedge clk or negedge rst_n) begin : mdl
    bit rise, fall, act;
    int fold;
    if (!rst_n) begin
      ph = 0; mc = 0; fc = 0; gc = 0; mm = 0; mi = 0; pf = 0;
    end else begin
      rise = fclk && !pf;
      fall = !fclk && pf;
      pf   = fclk;
      act  = mi ? fall : rise;
      fold = fc;
      if (!pdn_n) begin
        ph = 0; mc = 0; fc = 0; gc = 0;
      end else begin
        case (ph)
          0: begin mm = master; mi = i2s; ph = master ? 2 : 1; end
          1: if (act) ph = 2;
          2: begin
            if (act && fc < FMAX) fc++;
            if (mc == MW - 1) begin ph = 3; mc = 0; end else mc++;
          end
          3: if (act) begin
            if (fc < FMAX) fc++;
            if (gc == GF - 1) begin ph = 4; gc = 0; end else gc++;
          end
          4: begin
            if (act && fc < FMAX) fc++;
            if (fold >= (mm ? IM : IS)) ph = 5;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input logic act_v, input logic exp_v, input string req, input string what);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pwr_down_o, ph <= 2, ph == 0 ? "R1" : (ph == 1 ? "R4" : "R3"), "pwr_down");
      chk(filt_rst_o, ph <= 3, ph == 0 ? "R1" : "R5", "filt_rst");
      chk(zero_force_o, ph != 5, ph == 0 ? "R1" : "R7", "zero_force");
      chk(data_valid_o, ph == 5, ph == 0 ? "R1" : (flip ? "R8" : "R6"), "data_valid");
      chk((filt_rst_o || !pwr_down_o) && (zero_force_o || !filt_rst_o), 1'b1, "R9", "release order");
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run(input bit m, input bit f, input int n);
    pdn_n = 1'b0; master = m; i2s = f;
    wait_n(3);
    pdn_n = 1'b1;
    wait_n(n);
    chk(data_valid_o, 1'b1, "R6", "valid at end of sequence");
  endtask

  task automatic pulse_low();
    pdn_n = 1'b0;
    wait_n(1);
    chk(pwr_down_o, 1'b1, "R2", "restart pwr_down");
    chk(data_valid_o, 1'b0, "R2", "restart valid");
    pdn_n = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    wait_n(3);
    chk(pwr_down_o, 1'b1, "R1", "reset pwr_down");
    chk(filt_rst_o, 1'b1, "R1", "reset filt_rst");
    chk(zero_force_o, 1'b1, "R1", "reset zero_force");
    chk(data_valid_o, 1'b0, "R1", "reset valid");
    rst_n = 1'b1;
    wait_n(5);
    run(1'b1, 1'b0, 150);
    run(1'b1, 1'b1, 150);
    run(1'b0, 1'b0, 220);
    run(1'b0, 1'b1, 220);
    // restart during mclk wait, then during zero fill (R2)
    pdn_n = 1'b0; master = 1'b1; i2s = 1'b0; wait_n(3); pdn_n = 1'b1;
    wait_n(20); pulse_low(); wait_n(150);
    chk(data_valid_o, 1'b1, "R2", "valid after restart");
    pdn_n = 1'b0; master = 1'b0; i2s = 1'b1; wait_n(3); pdn_n = 1'b1;
    wait_n(80); pulse_low(); wait_n(220);
    chk(data_valid_o, 1'b1, "R2", "valid after late restart");
    // mode and format changed mid-sequence (R8)
    flip = 1'b1;
    pdn_n = 1'b0; master = 1'b0; i2s = 1'b0; wait_n(3); pdn_n = 1'b1;
    wait_n(30); master = 1'b1; i2s = 1'b1;
    wait_n(200);
    chk(data_valid_o, 1'b1, "R8", "valid after mode change");
    flip = 1'b0;
    // pin low while running (R1)
    pdn_n = 1'b0;
    wait_n(1);
    chk(zero_force_o, 1'b1, "R1", "zero_force after pin low");
    chk(data_valid_o, 1'b0, "R1", "valid after pin low");
    wait_n(4);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      done = 1'b1;
      summary();
      $finish;
    end
  end
endmodule